// File: doc/BRIEF.md
# Multiprocessor Interrupt Controller

This block gathers fifteen interrupt request lines, numbered 1 to 15, and presents each of a configurable number of processors with the number of the line it should service next. A rising edge on a request line latches the request. A line marked for broadcast latches into a private force register of every processor. Any other line latches into one pending register that all processors share. Each processor sees its own active set, which is the pending bits together with its own force bits, filtered by its own mask. A global level register splits the lines into a high tier and a low tier, and the high tier is always served first.

Software reaches the state through a word-wide register port with an 8-bit byte offset. Reads are combinational. A processor reports a serviced line on its acknowledge input, and that removes the line from the shared pending register and from that processor's force register. The force registers can set and clear bits in a single write, so several processors can change their force bits without a read-modify-write race. The processor-0 force register also has an alias offset that overwrites it directly.

Top module: `mp_irq_ctrl`

## Requirements
- R1: After reset, every register reads 0 and every processor's `irq_num` output is 0.
- R2: Bit 0 of every interrupt vector is reserved. Bit 0 of write data is dropped for the level, mask, force, alias and broadcast registers, and also for the clear register and acknowledge. Writing 0xFFFF to level reads back 0xFFFE, and request input bit 0 never latches.
- R3: A rising edge on a request line whose broadcast bit is 0 sets that bit in pending (offset 0x04). A line held high does not latch again after it has been cleared.
- R4: A rising edge on a line whose broadcast bit (offset 0x14) is 1 sets that bit in the force register of every processor and leaves pending unchanged.
- R5: For each processor, active = (pending | force[n]) & mask[n]. `irq_num[4n+3:4n]` is the highest-numbered active line whose level bit is 1. If there is none, it is the highest-numbered active line whose level bit is 0. If nothing is active, it is 0. The output is registered and reflects register state one clock after that state changes.
- R6: A write to offset 0x0C clears the written bits [15:1] in pending and in processor 0's force register. Offset 0x0C always reads 0.
- R7: A write to the force register of processor n (offset 0x80 + 4n) gives force = (old | wdata[15:1]) & ~wdata[31:17], where bit k+16 clears line k.
- R8: A write to offset 0x08 overwrites processor 0's force register with wdata[15:1]. A read of 0x08 returns that same register.
- R9: An acknowledge from processor n with line value k uses only k[3:0]. It clears that bit in pending and in processor n's force register only.
- R10: Pending ignores writes. Offset 0x10 and the extended slots from 0xC0 read 0 and ignore writes. Unmapped offsets, and mask and force slots at or above the processor count, also read 0 and ignore writes.
- R11: If a new request edge and a clear or acknowledge of the same bit fall in the same cycle, the bit stays set.
- R12: The register offsets are fixed as follows. Level is 0x00, pending 0x04, processor-0 force alias 0x08, clear 0x0C, status 0x10 and broadcast 0x14. Mask n is at 0x40 + 4n, force n at 0x80 + 4n, and extended slots start at 0xC0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| irq_lines | input | 16 | Request lines; bit k is line k, bit 0 unused |
| bus_we | input | 1 | Write strobe for the register port |
| bus_addr | input | 8 | Byte offset of the access |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for `bus_addr` (combinational) |
| ack_valid | input | NCPU | Per-processor acknowledge strobe |
| ack_line | input | 5*NCPU | Per-processor serviced line number, 5 bits each |
| irq_num | output | 4*NCPU | Per-processor line number to service, 4 bits each |

## Verification
The selection logic is tried with one line against an empty mask and against a partial mask. It is also tried with two lines in different level tiers, which shows whether the tier or the line number decides. A broadcast line is set alongside a shared pending line so that per-processor force bits can be told apart from shared pending bits. Acknowledge values with bit 4 set show whether the upper bit is ignored. A request edge that coincides with a clear of the same bit shows which of the two wins.

// File: rtl/mp_irq_ctrl.sv
module mp_irq_ctrl #(
  parameter int NCPU = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [15:0]       irq_lines,
  input  logic              bus_we,
  input  logic [7:0]        bus_addr,
  input  logic [31:0]       bus_wdata,
  output logic [31:0]       bus_rdata,
  input  logic [NCPU-1:0]   ack_valid,
  input  logic [5*NCPU-1:0] ack_line,
  output logic [4*NCPU-1:0] irq_num
);
  localparam logic [15:0] VEC = 16'hFFFE;

  logic [15:0] level_q, pend_q, bcast_q, lines_q;
  logic [15:0] mask_q  [NCPU];
  logic [15:0] force_q [NCPU];
  logic [15:0] pend_n;
  logic [15:0] force_n [NCPU];
  logic [15:0] ack_bits [NCPU];
  logic [15:0] ack_any, rise, clr_bits, wlo, whi;
  logic [4*NCPU-1:0] num_q;

  wire       slot_ok = (bus_addr[1:0] == 2'b00) && (32'(bus_addr[5:2]) < NCPU);
  wire [3:0] slot    = bus_addr[5:2];
  wire       wr_mask  = bus_we && bus_addr[7:6] == 2'b01 && slot_ok;
  wire       wr_force = bus_we && bus_addr[7:6] == 2'b10 && slot_ok;

  assign wlo      = bus_wdata[15:0] & VEC;
  assign whi      = bus_wdata[31:16] & VEC;
  assign rise     = irq_lines & ~lines_q & VEC;
  assign clr_bits = (bus_we && bus_addr == 8'h0C) ? wlo : 16'h0;

  function automatic logic [3:0] top_line(input logic [15:0] v);
    logic [3:0] r;
    r = 4'd0;
    for (int i = 1; i < 16; i++) if (v[i]) r = 4'(i);
    return r;
  endfunction

  always_comb begin
    ack_any = 16'h0;
    for (int c = 0; c < NCPU; c++) begin
      ack_bits[c] = ack_valid[c] ? ((16'd1 << ack_line[c*5 +: 4]) & VEC) : 16'h0;
      ack_any     = ack_any | ack_bits[c];
    end
    pend_n = (pend_q & ~clr_bits & ~ack_any) | (rise & ~bcast_q);
    for (int c = 0; c < NCPU; c++) begin
      force_n[c] = force_q[c];
      if (c == 0 && bus_we && bus_addr == 8'h08) force_n[c] = wlo;
      if (wr_force && 32'(slot) == c) force_n[c] = (force_n[c] | wlo) & ~whi;
      force_n[c] = force_n[c] & ~ack_bits[c] & ~((c == 0) ? clr_bits : 16'h0);
      force_n[c] = force_n[c] | (rise & bcast_q);
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      level_q <= '0; pend_q <= '0; bcast_q <= '0; lines_q <= '0; num_q <= '0;
      for (int c = 0; c < NCPU; c++) begin
        mask_q[c]  <= '0;
        force_q[c] <= '0;
      end
    end else begin
      lines_q <= irq_lines;
      pend_q  <= pend_n;
      if (bus_we && bus_addr == 8'h00) level_q <= wlo;
      if (bus_we && bus_addr == 8'h14) bcast_q <= wlo;
      for (int c = 0; c < NCPU; c++) begin
        logic [15:0] act;
        act = (pend_q | force_q[c]) & mask_q[c];
        num_q[c*4 +: 4] <= (|(act & level_q)) ? top_line(act & level_q)
                                               : top_line(act & ~level_q);
        force_q[c] <= force_n[c];
        if (wr_mask && 32'(slot) == c) mask_q[c] <= wlo;
      end
    end
  end

  assign irq_num = num_q;

  always_comb begin
    bus_rdata = 32'h0;
    case (bus_addr)
      8'h00: bus_rdata = {16'h0, level_q};
      8'h04: bus_rdata = {16'h0, pend_q};
      8'h08: bus_rdata = {16'h0, force_q[0]};
      8'h14: bus_rdata = {16'h0, bcast_q};
      default: begin
        if (slot_ok && bus_addr[7:6] == 2'b01) bus_rdata = {16'h0, mask_q[slot]};
        if (slot_ok && bus_addr[7:6] == 2'b10) bus_rdata = {16'h0, force_q[slot]};
      end
    endcase
  end

  p_status_zero_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_addr == 8'h10 || bus_addr == 8'h0C || bus_addr[7:6] == 2'b11) |-> bus_rdata == 32'h0);

  p_pend_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (clr_bits == 16'h0 && ack_valid == '0) |=> ((pend_q & $past(pend_q)) == $past(pend_q)));

  p_no_bit0_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (pend_q[0] == 1'b0 && level_q[0] == 1'b0 && bcast_q[0] == 1'b0));

  for (genvar g = 0; g < NCPU; g++) begin : g_chk
    p_masked_out_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (num_q[g*4 +: 4] != 4'd0) |-> ((($past(mask_q[g]) >> num_q[g*4 +: 4]) & 16'd1) != 16'd0));
    p_no_mask_quiet_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (mask_q[g] == 16'h0) |=> (num_q[g*4 +: 4] == 4'd0));
    p_bcast_fill_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (|(rise & bcast_q)) |=> ((force_q[g] & $past(rise & bcast_q)) == $past(rise & bcast_q)));
  end
endmodule

// File: tb/mp_irq_ctrl_tb.sv
module mp_irq_ctrl_tb_top;
  localparam int PERIOD = 10;
  localparam int NCPU   = 4;

  logic clk = 1'b0, rst_n = 1'b0, bus_we = 1'b0;
  logic [15:0] irq_lines = '0;
  logic [7:0]  bus_addr = '0;
  logic [31:0] bus_wdata = '0, bus_rdata;
  logic [NCPU-1:0]   ack_valid = '0;
  logic [5*NCPU-1:0] ack_line = '0;
  logic [4*NCPU-1:0] irq_num;
  int checks = 0, errors = 0;

  always #(PERIOD/2) clk = ~clk;

  mp_irq_ctrl #(.NCPU(NCPU)) dut_i (.*);

  task automatic check(input string req, input logic [31:0] got, input logic [31:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s: got %h expected %h", req, got, exp);
    end
  endtask

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    @(negedge clk); bus_we = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk); bus_we = 1'b0; bus_addr = 8'h00; bus_wdata = '0;
  endtask

  task automatic rd(input logic [7:0] a, output logic [31:0] d);
    bus_addr = a; #1; d = bus_rdata; bus_addr = 8'h00;
  endtask

  task automatic pulse(input logic [15:0] l);
    @(negedge clk); irq_lines = irq_lines | l;
    @(negedge clk); irq_lines = irq_lines & ~l;
  endtask

  task automatic ack(input int cpu, input logic [4:0] k);
    @(negedge clk); ack_valid[cpu] = 1'b1; ack_line[cpu*5 +: 5] = k;
    @(negedge clk); ack_valid = '0; ack_line = '0;
  endtask

  task automatic do_reset;
    @(negedge clk); rst_n = 1'b0; irq_lines = '0;
    tick(2); rst_n = 1'b1;
  endtask

  function automatic logic [3:0] num(input int cpu);
    return irq_num[cpu*4 +: 4];
  endfunction

  task automatic t_reset;
    logic [31:0] d;
    do_reset();
    foreach (dut_i.mask_q[i]) ;
    rd(8'h00, d); check("R1 level", d, 0);
    rd(8'h04, d); check("R1 pending", d, 0);
    rd(8'h14, d); check("R1 broadcast", d, 0);
    rd(8'h40, d); check("R1 mask0", d, 0);
    rd(8'h8C, d); check("R1 force3", d, 0);
    check("R1 irq_num", irq_num, 0);
  endtask

  task automatic t_pending_clear;
    logic [31:0] d;
    do_reset();
    wr(8'h40, 32'h0000_0028);
    @(negedge clk); irq_lines = 16'h0029;
    tick(2);
    rd(8'h04, d); check("R3 R2 pending latch", d, 32'h28);
    check("R5 cpu0 highest", num(0), 5);
    check("R5 cpu1 masked", num(1), 0);
    wr(8'h0C, 32'h0000_0021); tick(1);
    rd(8'h04, d); check("R6 pending after clear", d, 32'h08);
    rd(8'h0C, d); check("R6 clear reads zero", d, 0);
    check("R6 cpu0 after clear", num(0), 3);
    tick(2);
    rd(8'h04, d); check("R3 held line no relatch", d, 32'h08);
    irq_lines = '0;
  endtask

  task automatic t_level;
    logic [31:0] d;
    do_reset();
    wr(8'h00, 32'hFFFF_FFFF);
    rd(8'h00, d); check("R2 level bit0 dropped", d, 32'hFFFE);
    wr(8'h00, 32'h0000_0008);
    wr(8'h44, 32'h0000_FFFE);
    pulse(16'h0208); tick(1);
    check("R5 high tier first", num(1), 3);
    wr(8'h00, 32'h0000_0000); tick(1);
    check("R5 low tier highest", num(1), 9);
  endtask

  task automatic t_broadcast;
    logic [31:0] d;
    do_reset();
    wr(8'h14, 32'h0000_0041);
    rd(8'h14, d); check("R2 R12 broadcast reg", d, 32'h40);
    for (int c = 0; c < NCPU; c++) wr(8'(8'h40 + 4*c), 32'h0000_FFFE);
    pulse(16'h0040); tick(1);
    rd(8'h04, d); check("R4 pending untouched", d, 0);
    for (int c = 0; c < NCPU; c++) begin
      rd(8'(8'h80 + 4*c), d); check("R4 force set", d, 32'h40);
      check("R4 R5 output", num(c), 6);
    end
  endtask

  task automatic t_force_rw;
    logic [31:0] d;
    do_reset();
    wr(8'h48, 32'h0000_FFFE);
    wr(8'h88, 32'h0000_0046);
    rd(8'h88, d); check("R7 set", d, 32'h46);
    wr(8'h88, 32'h0004_0100);
    rd(8'h88, d); check("R7 set and clear", d, 32'h142);
    tick(1); check("R7 output", num(2), 8);
    wr(8'h88, 32'h0001_0001);
    rd(8'h88, d); check("R2 R7 bit0 ignored", d, 32'h142);
    wr(8'h08, 32'hFFFF_0013);
    rd(8'h80, d); check("R8 alias overwrite", d, 32'h12);
    wr(8'h08, 32'h0000_0020);
    rd(8'h08, d); check("R8 alias replace", d, 32'h20);
    rd(8'h88, d); check("R8 cpu2 untouched", d, 32'h142);
  endtask

  task automatic t_ack;
    logic [31:0] d;
    do_reset();
    wr(8'h14, 32'h0000_0040);
    for (int c = 0; c < NCPU; c++) wr(8'(8'h40 + 4*c), 32'h0000_FFFE);
    pulse(16'h0044); tick(1);
    check("R9 before ack", num(1), 6);
    ack(1, 5'h16); tick(1);
    rd(8'h84, d); check("R9 ack low bits", d, 0);
    rd(8'h80, d); check("R9 other cpu kept", d, 32'h40);
    check("R9 cpu1 falls back", num(1), 2);
    ack(3, 5'h02); tick(1);
    rd(8'h04, d); check("R9 pending acked", d, 0);
    check("R9 cpu1 idle", num(1), 0);
    check("R9 cpu0 still force", num(0), 6);
  endtask

  task automatic t_unmapped;
    logic [31:0] d;
    do_reset();
    wr(8'h04, 32'h0000_FFFF);
    wr(8'h10, 32'hFFFF_FFFF);
    wr(8'hC0, 32'h0000_000F);
    wr(8'h3C, 32'hFFFF_FFFF);
    wr(8'h50, 32'hFFFF_FFFF);
    wr(8'h90, 32'hFFFF_FFFF);
    wr(8'h41, 32'hFFFF_FFFF);
    rd(8'h04, d); check("R10 pending read-only", d, 0);
    rd(8'h10, d); check("R10 status zero", d, 0);
    rd(8'hC0, d); check("R10 extended zero", d, 0);
    rd(8'h50, d); check("R10 mask slot beyond count", d, 0);
    rd(8'h40, d); check("R10 mask0 untouched", d, 0);
    rd(8'h90, d); check("R10 force slot beyond count", d, 0);
    check("R10 outputs idle", irq_num, 0);
  endtask

  task automatic t_collision;
    logic [31:0] d;
    do_reset();
    pulse(16'h0080);
    rd(8'h04, d); check("R11 setup", d, 32'h80);
    @(negedge clk);
    irq_lines = 16'h0080; bus_we = 1'b1; bus_addr = 8'h0C; bus_wdata = 32'h80;
    @(negedge clk); bus_we = 1'b0; bus_addr = 8'h00; irq_lines = '0;
    rd(8'h04, d); check("R11 request beats clear", d, 32'h80);
    @(negedge clk); irq_lines = 16'h0080; ack_valid[2] = 1'b1; ack_line[10 +: 5] = 5'h07;
    @(negedge clk); ack_valid = '0; ack_line = '0; irq_lines = '0;
    rd(8'h04, d); check("R11 request beats ack", d, 32'h80);
  endtask

  initial begin
    #(PERIOD * 100000);
    errors++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    t_reset();
    t_pending_clear();
    t_level();
    t_broadcast();
    t_force_rw();
    t_ack();
    t_unmapped();
    t_collision();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule